// File: doc/BRIEF.md
# Gain-Scheduled PID Loop Filter

This block is the loop filter of a single-phase phase-locked loop. On each sample strobe it reads a signed phase-error word and produces an angular-frequency word. The error is the quadrature part of the tracked signal divided by its amplitude, and the loop drives that error toward zero. The frequency word is held inside a window of plus or minus a programmable deviation around a nominal frequency. All words are signed Q2.14: 16 bits, 14 of them fractional.

The proportional, integral and derivative gains each have a programmable low and high setting. With scheduling enabled, each gain moves linearly from its low setting at zero error to its high setting at an error threshold of 2^thr_exp LSBs, and stays there above it. With scheduling disabled, only the low settings apply. The derivative path uses a first-order smoothing coefficient instead of a pure difference. The integrator stops accumulating in a direction that would push the output further out of the window. A synchronous reset loads the integrator so that the output starts at the nominal frequency.

Top module: `pll_loop_filter`

## Requirements
- R1: While rst is high at a clock edge, freq_out takes the value of nom_freq at that edge, valid goes low, the integrator is loaded with nom_freq, and the derivative state and stored previous error are cleared. Therefore a strobe with all gains zero yields nom_freq.
- R2: With sched_en low, each gain equals its low setting, and the high settings have no effect on freq_out.
- R3: With sched_en high, a gain is hi when mag >= 2^thr_exp. Otherwise it is lo + floor((hi-lo)*mag / 2^thr_exp). Here mag is |err|, with -32768 taken as 32767.
- R4: Every product is qmul(a,b) = floor((a*b + 8192) / 16384), saturated to the 20-bit signed internal range. The proportional term is qmul(kp, err).
- R5: On each strobe the integrator adds qmul(ki, err), saturated to 20 bits, unless R8 holds it. The output is integrator + proportional term + derivative term.
- R6: The derivative term is given by raw = qmul(kd, err - previous err) and d = d_prev + qmul(d_alpha, raw - d_prev). It uses the updated d in the same sample. A d_alpha of 16384 gives the unsmoothed difference.
- R7: freq_out is the sum clamped to [nom_freq - max_dev, nom_freq + max_dev] and then to the 16-bit signed range. max_dev is nonnegative.
- R8: The integrator keeps its old value for a sample in two cases. The first is when its increment is positive and the trial sum (using the updated integrator) lies above the upper limit. The second is when the increment is negative and the trial sum lies below the lower limit.
- R9: valid is high exactly in the cycle after a clock edge that sampled strobe high. freq_out changes only at such edges or at reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| strobe | input | 1 | Sample strobe, one cycle per sample |
| sched_en | input | 1 | Gain scheduling enable |
| err | input | 16 | Normalized phase error, Q2.14 |
| nom_freq | input | 16 | Nominal angular frequency, Q2.14 |
| max_dev | input | 16 | Allowed deviation from nominal, nonnegative, Q2.14 |
| kp_lo | input | 16 | Proportional gain, low setting |
| kp_hi | input | 16 | Proportional gain, high setting |
| ki_lo | input | 16 | Integral gain, low setting |
| ki_hi | input | 16 | Integral gain, high setting |
| kd_lo | input | 16 | Derivative gain, low setting |
| kd_hi | input | 16 | Derivative gain, high setting |
| thr_exp | input | 4 | Scheduling threshold exponent, threshold = 2^thr_exp LSB |
| d_alpha | input | 16 | Derivative smoothing coefficient, 0 to 16384 |
| freq_out | output | 16 | Angular frequency output, Q2.14 |
| valid | output | 1 | High for one cycle after each sampled strobe |

## Verification
The window assertion assumes two things. First, max_dev is never negative. Second, nom_freq and max_dev have not changed since the sampled strobe. The random stimulus therefore draws max_dev only from the nonnegative range and changes nom_freq only through a reset. The derivative filter stays bounded only for smoothing coefficients in 0..16384, so d_alpha is drawn from that span. Gains and the threshold exponent range freely, because the scheduled gain is bounded by its two settings whatever their order.

// File: rtl/pll_lf_pkg.sv
package pll_lf_pkg;
  parameter int DW = 16;            // port word width
  parameter int FW = 14;            // fractional bits
  parameter int AW = DW + 4;        // internal accumulator width
  parameter int PW = 2 * AW;        // product width
  parameter int KW = 4;             // threshold exponent width
  parameter int NGAIN = 3;          // P, I, D

  typedef logic signed [DW-1:0] word_t;
  typedef logic signed [AW-1:0] acc_t;
  typedef logic signed [PW-1:0] prod_t;

  localparam acc_t  ACC_MAX  = {1'b0, {(AW-1){1'b1}}};
  localparam acc_t  ACC_MIN  = {1'b1, {(AW-1){1'b0}}};
  localparam word_t WORD_MAX = {1'b0, {(DW-1){1'b1}}};
  localparam word_t WORD_MIN = {1'b1, {(DW-1){1'b0}}};
  localparam prod_t HALF_LSB = prod_t'(1) <<< (FW-1);

  function automatic acc_t sat_acc(input prod_t x);
    if (x > prod_t'(ACC_MAX)) return ACC_MAX;
    if (x < prod_t'(ACC_MIN)) return ACC_MIN;
    return acc_t'(x[AW-1:0]);
  endfunction

  function automatic acc_t ext(input word_t w);
    return acc_t'(w);
  endfunction

  function automatic acc_t add_sat(input acc_t a, input acc_t b);
    return sat_acc(prod_t'(a) + prod_t'(b));
  endfunction

  function automatic acc_t sub_sat(input acc_t a, input acc_t b);
    return sat_acc(prod_t'(a) - prod_t'(b));
  endfunction

  // Q-format multiply, round half up, saturate to accumulator width
  function automatic acc_t qmul(input acc_t a, input acc_t b);
    prod_t p;
    p = prod_t'(a) * prod_t'(b) + HALF_LSB;
    return sat_acc(p >>> FW);
  endfunction

  function automatic word_t sat_word(input acc_t x);
    if (x > ext(WORD_MAX)) return WORD_MAX;
    if (x < ext(WORD_MIN)) return WORD_MIN;
    return word_t'(x[DW-1:0]);
  endfunction

  function automatic acc_t clamp(input acc_t x, input acc_t lo, input acc_t hi);
    if (x > hi) return hi;
    if (x < lo) return lo;
    return x;
  endfunction

  // magnitude of a word, most negative value folded to the maximum
  function automatic acc_t mag_of(input word_t e);
    if (e == WORD_MIN) return ext(WORD_MAX);
    if (e < 0) return -ext(e);
    return ext(e);
  endfunction
endpackage

// File: rtl/pll_lf_gain_sched.sv
module pll_lf_gain_sched
  import pll_lf_pkg::*;
#(
  parameter int KWID = KW
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            sched_en,
  input  word_t           err,
  input  word_t           g_lo,
  input  word_t           g_hi,
  input  logic [KWID-1:0] thr_exp,
  output word_t           g_out
);
  acc_t  mag;
  acc_t  span;
  prod_t ramp;
  prod_t thr;
  logic  above_thr;

  always_comb begin
    mag       = mag_of(err);
    span      = sub_sat(ext(g_hi), ext(g_lo));
    thr       = prod_t'(1) <<< thr_exp;
    above_thr = (prod_t'(mag) >= thr);
    ramp      = (prod_t'(span) * prod_t'(mag)) >>> thr_exp;
    if (!sched_en)
      g_out = g_lo;
    else if (above_thr)
      g_out = g_hi;
    else
      g_out = sat_word(sat_acc(prod_t'(ext(g_lo)) + ramp));
  end

  // R3: a scheduled gain never leaves the span of its two settings
  p_gain_span_r3: assert property (@(posedge clk) disable iff (rst)
    (g_lo <= g_hi) ? (g_out >= g_lo && g_out <= g_hi)
                   : (g_out <= g_lo && g_out >= g_hi));
endmodule

// File: rtl/pll_lf_deriv.sv
module pll_lf_deriv
  import pll_lf_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  strobe,
  input  word_t err,
  input  word_t kd,
  input  word_t alpha,
  output acc_t  d_term
);
  word_t err_prev;
  acc_t  d_state;
  acc_t  raw;
  acc_t  delta;

  always_comb begin
    delta  = sub_sat(ext(err), ext(err_prev));
    raw    = qmul(ext(kd), delta);
    d_term = add_sat(d_state, qmul(ext(alpha), sub_sat(raw, d_state)));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      err_prev <= '0;
      d_state  <= '0;
    end else if (strobe) begin
      err_prev <= err;
      d_state  <= d_term;
    end
  end

  // R1: reset clears the derivative filter state
  p_dclear_r1: assert property (@(posedge clk) rst |=> (d_state == '0 && err_prev == '0));
  // R6: without a strobe the filter state is kept
  p_dhold_r6: assert property (@(posedge clk) disable iff (rst)
    !strobe |=> $stable(d_state));
endmodule

// File: rtl/pll_lf_integ.sv
module pll_lf_integ
  import pll_lf_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  strobe,
  input  word_t nom_freq,
  input  word_t max_dev,
  input  acc_t  p_term,
  input  acc_t  d_term,
  input  acc_t  i_inc,
  output word_t freq_out,
  output logic  hold_up,
  output logic  hold_dn
);
  acc_t integ;
  acc_t integ_try;
  acc_t integ_use;
  acc_t sum_try;
  acc_t sum_use;
  acc_t lim_hi;
  acc_t lim_lo;
  word_t out_next;

  always_comb begin
    lim_hi    = add_sat(ext(nom_freq), ext(max_dev));
    lim_lo    = sub_sat(ext(nom_freq), ext(max_dev));
    integ_try = add_sat(integ, i_inc);
    sum_try   = add_sat(add_sat(integ_try, p_term), d_term);
    hold_up   = (sum_try > lim_hi) && (i_inc > 0);
    hold_dn   = (sum_try < lim_lo) && (i_inc < 0);
    integ_use = (hold_up || hold_dn) ? integ : integ_try;
    sum_use   = add_sat(add_sat(integ_use, p_term), d_term);
    out_next  = sat_word(clamp(sum_use, lim_lo, lim_hi));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      integ    <= ext(nom_freq);
      freq_out <= nom_freq;
    end else if (strobe) begin
      integ    <= integ_use;
      freq_out <= out_next;
    end
  end

  // R8: a held sample leaves the integrator untouched
  p_windup_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (strobe && (hold_up || hold_dn)) |=> (integ == $past(integ)));
  // R8: the two hold conditions exclude each other
  p_hold_excl_r8: assert property (@(posedge clk) disable iff (rst)
    !(hold_up && hold_dn));
  // R1: reset loads the nominal frequency
  p_reset_load_r1: assert property (@(posedge clk)
    rst |=> (freq_out == $past(nom_freq) && integ == ext($past(nom_freq))));
  // R9: output moves only on a strobe
  p_out_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !strobe |=> $stable(freq_out));
endmodule

// File: rtl/pll_loop_filter.sv
module pll_loop_filter
  import pll_lf_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 strobe,
  input  logic                 sched_en,
  input  logic signed [DW-1:0] err,
  input  logic signed [DW-1:0] nom_freq,
  input  logic signed [DW-1:0] max_dev,
  input  logic signed [DW-1:0] kp_lo,
  input  logic signed [DW-1:0] kp_hi,
  input  logic signed [DW-1:0] ki_lo,
  input  logic signed [DW-1:0] ki_hi,
  input  logic signed [DW-1:0] kd_lo,
  input  logic signed [DW-1:0] kd_hi,
  input  logic [KW-1:0]        thr_exp,
  input  logic signed [DW-1:0] d_alpha,
  output logic signed [DW-1:0] freq_out,
  output logic                 valid
);
  localparam int GP = 0;
  localparam int GI = 1;
  localparam int GD = 2;

  word_t g_lo  [NGAIN];
  word_t g_hi  [NGAIN];
  word_t g_cur [NGAIN];
  acc_t  p_term;
  acc_t  i_inc;
  acc_t  d_term;
  logic  hold_up;
  logic  hold_dn;

  assign g_lo[GP] = kp_lo;
  assign g_lo[GI] = ki_lo;
  assign g_lo[GD] = kd_lo;
  assign g_hi[GP] = kp_hi;
  assign g_hi[GI] = ki_hi;
  assign g_hi[GD] = kd_hi;

  for (genvar gi = 0; gi < NGAIN; gi++) begin : g_sched
    pll_lf_gain_sched #(.KWID(KW)) u_sched (
      .clk      (clk),
      .rst      (rst),
      .sched_en (sched_en),
      .err      (err),
      .g_lo     (g_lo[gi]),
      .g_hi     (g_hi[gi]),
      .thr_exp  (thr_exp),
      .g_out    (g_cur[gi])
    );
  end

  always_comb begin
    p_term = qmul(ext(g_cur[GP]), ext(err));
    i_inc  = qmul(ext(g_cur[GI]), ext(err));
  end

  pll_lf_deriv u_deriv (
    .clk    (clk),
    .rst    (rst),
    .strobe (strobe),
    .err    (err),
    .kd     (g_cur[GD]),
    .alpha  (d_alpha),
    .d_term (d_term)
  );

  pll_lf_integ u_integ (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .nom_freq (nom_freq),
    .max_dev  (max_dev),
    .p_term   (p_term),
    .d_term   (d_term),
    .i_inc    (i_inc),
    .freq_out (freq_out),
    .hold_up  (hold_up),
    .hold_dn  (hold_dn)
  );

  always_ff @(posedge clk) begin
    if (rst) valid <= 1'b0;
    else     valid <= strobe;
  end

  // R9: valid follows each sampled strobe by one cycle
  p_valid_after_r9: assert property (@(posedge clk) disable iff (rst)
    strobe |=> valid);
  p_valid_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    !strobe |=> !valid);
  // R1: valid is low after reset
  p_reset_valid_r1: assert property (@(posedge clk) rst |=> !valid);
  // R7: output stays in the window when the window is unchanged
  p_band_r7: assert property (@(posedge clk) disable iff (rst)
    (valid && $stable(nom_freq) && $stable(max_dev) && max_dev >= 0) |->
      (ext(freq_out) <= add_sat(ext(nom_freq), ext(max_dev)) &&
       ext(freq_out) >= sub_sat(ext(nom_freq), ext(max_dev))));
  // R8: integrator holds only when the trial sum leaves the window
  p_hold_cause_r8: assert property (@(posedge clk) disable iff (rst)
    hold_up |-> (i_inc > 0));
endmodule

// File: tb/pll_loop_filter_bench.sv
module pll_loop_filter_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic strobe = 1'b0;
  logic sched_en = 1'b0;
  logic signed [15:0] err = '0, nom_freq = '0, max_dev = '0;
  logic signed [15:0] kp_lo = '0, kp_hi = '0, ki_lo = '0, ki_hi = '0, kd_lo = '0, kd_hi = '0;
  logic [3:0] thr_exp = '0;
  logic signed [15:0] d_alpha = '0;
  logic signed [15:0] freq_out;
  logic valid;

  int n_chk = 0;
  int n_bad = 0;
  longint m_int, m_d, m_eprev;

  always #5 clk = ~clk;

  pll_loop_filter u_pll_loop_filter (
    .clk(clk), .rst(rst), .strobe(strobe), .sched_en(sched_en), .err(err),
    .nom_freq(nom_freq), .max_dev(max_dev), .kp_lo(kp_lo), .kp_hi(kp_hi),
    .ki_lo(ki_lo), .ki_hi(ki_hi), .kd_lo(kd_lo), .kd_hi(kd_hi),
    .thr_exp(thr_exp), .d_alpha(d_alpha), .freq_out(freq_out), .valid(valid)
  );

  function automatic longint msat(longint x, int bits);
    longint lim = longint'(1) << (bits - 1);
    if (x > lim - 1) return lim - 1;
    if (x < -lim) return -lim;
    return x;
  endfunction

  function automatic longint mq(longint a, longint b);
    return msat((a * b + 8192) >>> 14, 20);
  endfunction

  function automatic longint mgain(longint lo, longint hi, longint e, int k, bit en);
    longint mag;
    if (!en) return lo;
    mag = (e < 0) ? -e : e;
    if (mag > 32767) mag = 32767;
    if (mag >= (longint'(1) << k)) return hi;
    return lo + (((hi - lo) * mag) >>> k);
  endfunction

  // model one sample from current inputs, returns expected output
  function automatic longint mstep();
    longint e, kp, ki, kd, p, inc, raw, dn, itry, strial, iuse, s, hi, lo, o;
    e   = longint'(err);
    kp  = mgain(longint'(kp_lo), longint'(kp_hi), e, int'(thr_exp), sched_en);
    ki  = mgain(longint'(ki_lo), longint'(ki_hi), e, int'(thr_exp), sched_en);
    kd  = mgain(longint'(kd_lo), longint'(kd_hi), e, int'(thr_exp), sched_en);
    p   = mq(kp, e);
    inc = mq(ki, e);
    raw = mq(kd, e - m_eprev);
    dn  = msat(m_d + mq(longint'(d_alpha), msat(raw - m_d, 20)), 20);
    hi  = longint'(nom_freq) + longint'(max_dev);
    lo  = longint'(nom_freq) - longint'(max_dev);
    itry   = msat(m_int + inc, 20);
    strial = msat(msat(itry + p, 20) + dn, 20);
    if ((strial > hi && inc > 0) || (strial < lo && inc < 0)) iuse = m_int;
    else iuse = itry;
    s = msat(msat(iuse + p, 20) + dn, 20);
    o = (s > hi) ? hi : (s < lo) ? lo : s;
    m_int = iuse; m_d = dn; m_eprev = e;
    return msat(o, 16);
  endfunction

  task automatic check(longint act, longint exp, string tag);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_reset(logic signed [15:0] nom);
    @(negedge clk);
    rst = 1'b1; nom_freq = nom; strobe = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    m_int = longint'(nom); m_d = 0; m_eprev = 0;
    check(longint'(freq_out), longint'(nom), "R1 reset output");
    check(longint'(valid), 0, "R1 reset valid");
  endtask

  task automatic sample(logic signed [15:0] e, string tag, output longint got);
    longint exp;
    @(negedge clk);
    err = e; strobe = 1'b1;
    exp = mstep();
    @(negedge clk);
    strobe = 1'b0;
    check(longint'(valid), 1, "R9 valid after strobe");
    check(longint'(freq_out), exp, tag);
    got = longint'(freq_out);
  endtask

  task automatic zero_gains();
    kp_lo = 0; kp_hi = 0; ki_lo = 0; ki_hi = 0; kd_lo = 0; kd_hi = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    longint got;
    logic signed [15:0] hold_val;
    void'($urandom(32'd4242));
    m_int = 0; m_d = 0; m_eprev = 0;
    max_dev = 16'sd8000; d_alpha = 16'sd16384;
    zero_gains();
    do_reset(16'sd3000);
    // R1: integrator preloaded, zero gains give nominal
    sample(16'sd1234, "R1 zero gains", got);
    check(got, 3000, "R1 nominal after reset");

    // R4: proportional only, gain 1.0
    kp_lo = 16'sd16384;
    do_reset(16'sd0);
    sample(16'sd1000, "R4 prop", got);
    check(got, 1000, "R4 prop unity");
    kp_lo = 16'sd8192;
    sample(-16'sd3, "R4 rounding", got);
    check(got, -1, "R4 round half up of -1.5");

    // R2: schedule off ignores high settings
    kp_lo = 16'sd8192; kp_hi = 16'sd32767; sched_en = 1'b0;
    sample(16'sd4000, "R2 low gain", got);
    check(got, 2000, "R2 high setting ignored");

    // R3: ramp midpoint, threshold, and most negative error
    sched_en = 1'b1; kp_lo = 16'sd0; kp_hi = 16'sd16384; thr_exp = 4'd10;
    sample(16'sd512, "R3 midpoint", got);
    check(got, 256, "R3 half gain");
    sample(16'sd1024, "R3 at threshold", got);
    check(got, 1024, "R3 high gain");
    sample(-16'sd32768, "R3 most negative clamps R7", got);
    check(got, -8000, "R7 lower limit");
    sched_en = 1'b0;

    // R5: integration
    zero_gains(); ki_lo = 16'sd16384;
    do_reset(16'sd0);
    sample(16'sd100, "R5 integ 1", got);
    sample(16'sd100, "R5 integ 2", got);
    check(got, 200, "R5 accumulated");

    // R8: anti-windup at the upper limit
    max_dev = 16'sd3000;
    do_reset(16'sd0);
    sample(16'sd1000, "R8 a", got);
    sample(16'sd1000, "R8 b", got);
    sample(16'sd1000, "R8 c", got);
    sample(16'sd1000, "R8 held", got);
    check(got, 3000, "R8 at limit");
    sample(-16'sd1000, "R8 release", got);
    check(got, 2000, "R8 no windup");

    // R6: derivative, raw and smoothed
    zero_gains(); kd_lo = 16'sd16384; max_dev = 16'sd8000;
    d_alpha = 16'sd8192;
    do_reset(16'sd0);
    sample(16'sd1000, "R6 step", got);
    check(got, 500, "R6 half smoothing");
    sample(16'sd1000, "R6 decay", got);
    check(got, 250, "R6 decay");

    // R9: idle cycles keep output and drop valid
    hold_val = freq_out;
    @(negedge clk); err = 16'sd5000;
    @(negedge clk);
    check(longint'(valid), 0, "R9 valid low when idle");
    check(longint'(freq_out), longint'(hold_val), "R9 output held");

    // random mix
    for (int it = 0; it < 400; it++) begin
      if (it % 50 == 0) begin
        max_dev = 16'($urandom_range(0, 20000));
        do_reset(16'($signed(17'($urandom_range(0, 32768)) - 17'sd16384)));
      end
      sched_en = 1'($urandom_range(0, 1));
      kp_lo = 16'($urandom); kp_hi = 16'($urandom);
      ki_lo = 16'($urandom_range(0, 4000)); ki_hi = 16'($urandom_range(0, 4000));
      kd_lo = 16'($urandom); kd_hi = 16'($urandom);
      thr_exp = 4'($urandom_range(0, 15));
      d_alpha = 16'($urandom_range(0, 16384));
      sample(16'($urandom), "R2 R3 R5 R6 R7 R8 random", got);
      for (int g = 0; g < int'($urandom_range(0, 2)); g++) begin
        hold_val = freq_out;
        @(negedge clk);
        check(longint'(valid), 0, "R9 gap valid");
        check(longint'(freq_out), longint'(hold_val), "R9 gap hold");
      end
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule